// File: doc/BRIEF.md
# Register-File Load Instruction Executor

This block carries out the byte-move instructions of an 8-bit controller whose whole data space is a 256-byte register file. It accepts an opcode byte and then one or two operand bytes on a ready/valid byte stream. From the opcode it works out where the source value comes from: an immediate byte, a register, a register reached through a pointer, or a register at base-plus-offset. It works out the destination the same way. It then moves exactly one byte through a single-port register-file interface that reads combinationally and writes on the clock edge.

A 4-bit group select picks which sixteen registers act as the working set. Working register `n` lives at address `{grp_sel, n}`. Any full 8-bit address field whose upper nibble is `E` hex is taken as a working-register reference and is remapped the same way. Each instruction runs for a fixed number of cycles, and a one-cycle `done` pulse marks its last cycle. Codes outside the load family are flagged and dropped.

Top module: `ldx_load_exec`

## Requirements
- R1: While `rst_n` is low at a clock edge the block returns to idle. After that edge `in_ready` is 1 and `done`, `illegal` and `rf_we` are 0.
- R2: Working register `n` (4 bits) is at register-file address `{grp_sel, n}`. An 8-bit address field `f` with `f[7:4] == 4'hE` means working register `f[3:0]`. Any other field value is used unchanged as the address. An address read out of a pointer register, and an indexed sum, are used unchanged.
- R3: An opcode `{r, L}` acts on working register `r` as follows. With `L = 4'hC` it loads `r` with the operand byte. With `L = 4'h8` it loads `r` from the register that the operand field names. With `L = 4'h9` it stores `r` into the register that the operand field names.
- R4: For opcodes `E3h` and `F3h` the operand byte is `{d, s}`. `E3h` loads working register `d` from the register whose address is held in working register `s`. `F3h` stores working register `s` into the register whose address is held in working register `d`.
- R5: For opcodes `E4h`, `E5h` and `F5h`, the first operand byte is the source field and the second is the destination field. `E4h` copies source to destination. `E5h` reads through the source as a pointer. `F5h` writes through the destination as a pointer.
- R6: For opcodes `E6h` and `E7h`, the first operand byte is the destination field and the second is an immediate value. `E6h` writes the value to the destination. `E7h` writes it through the destination as a pointer.
- R7: For opcodes `C7h` and `D7h`, the first operand byte is `{a, x}` and the second is an offset `k`. The effective address is `(k + contents of working register x) mod 256`. `C7h` loads working register `a` from that address. `D7h` stores working register `a` to that address.
- R8: Counting the opcode-accept cycle as cycle 1, `done` pulses in cycle 6 for the one-operand forms (`xC`, `x8`, `x9`, `E3`, `F3`). It pulses in cycle 10 for the two-operand forms. The next opcode can be accepted in the cycle after `done`.
- R9: A legal instruction makes exactly one register-file write. No other register (source, pointer or index) changes.
- R10: An opcode outside the load family raises `illegal` and `done` together in the cycle after it is accepted. It makes no register-file write and consumes no operand bytes.
- R11: `in_ready` is 1 exactly while the block waits for an opcode or operand byte. Each cycle an expected operand byte is held back (`in_valid` low) lengthens the instruction by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction byte on `in_data` is valid |
| in_data | input | 8 | Opcode or operand byte |
| in_ready | output | 1 | Block takes `in_data` when `in_valid` is also high |
| grp_sel | input | 4 | Upper nibble of the register pointer; selects the working group |
| rf_addr | output | 8 | Register-file address |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data for `rf_addr`, same cycle |
| done | output | 1 | One-cycle pulse on the final cycle of an instruction |
| illegal | output | 1 | Pulse marking a rejected opcode (coincides with `done`) |

## Verification
The bench targets these corner cases:

- **Address field with upper nibble `E` hex.** A design that skips the redirection moves data to or from the raw `Ex` addresses instead of the working group.
- **Indirect forms whose pointer is itself a working-register reference.** A design that remaps the fetched pointer value a second time writes to the wrong register.
- **Indexed address that wraps past FFh.** A design that widens or saturates the sum touches the wrong location.
- **Operand order of the two-byte forms.** Register-to-register, immediate and pointer forms are each exercised, so swapped fields show up as writes to the wrong register.
- **Held-back operand bytes.** A design that counts cycles by wall clock ends early, and its `done` lands in the wrong cycle.
- **Rejected opcodes.** A design that lets them through swallows the next opcode or writes to the file.

// File: rtl/ldx_pkg.sv
// Package ldx_pkg
// Shared constants, the instruction-form enumeration and the per-instruction
// transfer plan used by the load executor. Assumes an 8-bit data path and a
// 16-entry working group addressed by a 4-bit group select.
package ldx_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam logic [NIB_W-1:0] WGRP_TAG = 4'hE;

    typedef logic [BYTE_W-1:0] rbyte_t;
    typedef logic [NIB_W-1:0]  nib_t;

    typedef enum logic [3:0] {
        FM_IMM_WR,   // xC : working <- immediate
        FM_LD_WR,    // x8 : working <- field
        FM_ST_WR,    // x9 : field <- working
        FM_LD_IND,   // E3 : working <- @working
        FM_ST_IND,   // F3 : @working <- working
        FM_RR,       // E4 : field <- field
        FM_R_IR,     // E5 : field <- @field
        FM_R_IM,     // E6 : field <- immediate
        FM_IR_IM,    // E7 : @field <- immediate
        FM_IR_R,     // F5 : @field <- field
        FM_LD_IDX,   // C7 : working <- [k + working]
        FM_ST_IDX,   // D7 : [k + working] <- working
        FM_BAD       // anything else
    } ld_form_e;

    typedef struct packed {
        logic   need_ptr;    // a pointer/index register is read first
        logic   ptr_is_src;  // pointer result addresses the source (else the destination)
        logic   src_imm;     // source value is an operand byte
        rbyte_t ptr_addr;    // where the pointer/index lives
        rbyte_t off;         // added to the pointer value (zero unless indexed)
        rbyte_t src_addr;    // direct source address
        rbyte_t dst_addr;    // direct destination address
        rbyte_t imm;         // immediate value
    } ld_plan_t;

    // Address of working register n in group grp.
    function automatic rbyte_t wreg_addr(input nib_t grp, input nib_t n);
        return {grp, n};
    endfunction

    // Resolve an 8-bit register field, remapping the E-tagged working form.
    function automatic rbyte_t field_addr(input nib_t grp, input rbyte_t f);
        return (f[7:4] == WGRP_TAG) ? wreg_addr(grp, f[3:0]) : f;
    endfunction

    // Forms that carry two operand bytes.
    function automatic logic form_long(input ld_form_e f);
        return (f inside {FM_RR, FM_R_IR, FM_R_IM, FM_IR_IM, FM_IR_R,
                          FM_LD_IDX, FM_ST_IDX});
    endfunction

endpackage

// File: rtl/ldx_decode.sv
// Module ldx_decode
// Classifies an opcode byte into a load form and reports whether it carries
// two operand bytes. Purely combinational; anything outside the load family
// maps to FM_BAD.
module ldx_decode
    import ldx_pkg::*;
(
    input  rbyte_t   opcode,
    output ld_form_e form,
    output logic     long_form
);

    // Low-nibble forms first, then the fixed opcodes.
    always_comb begin
        case (opcode[3:0])
            4'hC:    form = FM_IMM_WR;
            4'h8:    form = FM_LD_WR;
            4'h9:    form = FM_ST_WR;
            default: begin
                case (opcode)
                    8'hE3:   form = FM_LD_IND;
                    8'hF3:   form = FM_ST_IND;
                    8'hE4:   form = FM_RR;
                    8'hE5:   form = FM_R_IR;
                    8'hE6:   form = FM_R_IM;
                    8'hE7:   form = FM_IR_IM;
                    8'hF5:   form = FM_IR_R;
                    8'hC7:   form = FM_LD_IDX;
                    8'hD7:   form = FM_ST_IDX;
                    default: form = FM_BAD;
                endcase
            end
        endcase
    end

    // Operand-byte count follows from the form.
    always_comb long_form = form_long(form);

endmodule

// File: rtl/ldx_operand_map.sv
// Module ldx_operand_map
// Turns a decoded form and its latched operand bytes into a transfer plan:
// which register is read as a pointer, where the source and destination are,
// and the immediate. Assumes the operand bytes are stable while the plan is
// used; the group select is taken live.
module ldx_operand_map
    import ldx_pkg::*;
(
    input  ld_form_e form,
    input  nib_t     wsel,
    input  rbyte_t   b1,
    input  rbyte_t   b2,
    input  nib_t     grp,
    output ld_plan_t plan
);

    // Build the plan for the current form.
    always_comb begin
        plan = '0;
        case (form)
            FM_IMM_WR: begin
                plan.src_imm  = 1'b1;
                plan.imm      = b1;
                plan.dst_addr = wreg_addr(grp, wsel);
            end
            FM_LD_WR: begin
                plan.src_addr = field_addr(grp, b1);
                plan.dst_addr = wreg_addr(grp, wsel);
            end
            FM_ST_WR: begin
                plan.src_addr = wreg_addr(grp, wsel);
                plan.dst_addr = field_addr(grp, b1);
            end
            FM_LD_IND: begin
                plan.need_ptr   = 1'b1;
                plan.ptr_is_src = 1'b1;
                plan.ptr_addr   = wreg_addr(grp, b1[3:0]);
                plan.dst_addr   = wreg_addr(grp, b1[7:4]);
            end
            FM_ST_IND: begin
                plan.need_ptr = 1'b1;
                plan.ptr_addr = wreg_addr(grp, b1[7:4]);
                plan.src_addr = wreg_addr(grp, b1[3:0]);
            end
            FM_RR: begin
                plan.src_addr = field_addr(grp, b1);
                plan.dst_addr = field_addr(grp, b2);
            end
            FM_R_IR: begin
                plan.need_ptr   = 1'b1;
                plan.ptr_is_src = 1'b1;
                plan.ptr_addr   = field_addr(grp, b1);
                plan.dst_addr   = field_addr(grp, b2);
            end
            FM_IR_R: begin
                plan.need_ptr = 1'b1;
                plan.ptr_addr = field_addr(grp, b2);
                plan.src_addr = field_addr(grp, b1);
            end
            FM_R_IM: begin
                plan.src_imm  = 1'b1;
                plan.imm      = b2;
                plan.dst_addr = field_addr(grp, b1);
            end
            FM_IR_IM: begin
                plan.need_ptr = 1'b1;
                plan.src_imm  = 1'b1;
                plan.imm      = b2;
                plan.ptr_addr = field_addr(grp, b1);
            end
            FM_LD_IDX: begin
                plan.need_ptr   = 1'b1;
                plan.ptr_is_src = 1'b1;
                plan.off        = b2;
                plan.ptr_addr   = wreg_addr(grp, b1[3:0]);
                plan.dst_addr   = wreg_addr(grp, b1[7:4]);
            end
            FM_ST_IDX: begin
                plan.need_ptr = 1'b1;
                plan.off      = b2;
                plan.ptr_addr = wreg_addr(grp, b1[3:0]);
                plan.src_addr = wreg_addr(grp, b1[7:4]);
            end
            default: plan = '0;
        endcase
    end

endmodule

// File: rtl/ldx_cycle_timer.sv
// Module ldx_cycle_timer
// Counts the cycles of one instruction. It loads on the opcode-accept edge so
// that the following cycle reads 2. It advances only while the executor is not
// waiting on a withheld operand byte, and reports when the count reaches the
// length of the form. Assumes the work of every form ends before its length.
module ldx_cycle_timer #(
    parameter int SHORT_CYCLES = 6,
    parameter int LONG_CYCLES  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_sel,
    input  logic advance,
    output logic at_end
);

    localparam int CNT_W = $clog2(LONG_CYCLES + 1);
    localparam logic [CNT_W-1:0] FIRST_CNT = CNT_W'(2);
    localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(SHORT_CYCLES);
    localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(LONG_CYCLES);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;

    // Load on start, then step toward the form's length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            target <= SHORT_LEN;
        end else if (start) begin
            cnt    <= FIRST_CNT;
            target <= long_sel ? LONG_LEN : SHORT_LEN;
        end else if (advance && (cnt < target)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // End of the instruction's fixed length.
    always_comb at_end = (cnt == target);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= target);

endmodule

// File: rtl/ldx_load_exec.sv
// Module ldx_load_exec
// Executes the load family of a register-file controller. It accepts an opcode
// and its operand bytes on a ready/valid stream. If the form needs one, it reads
// a pointer or index register, then reads the source unless the source is
// immediate, then makes one write. It holds until the form's fixed cycle count
// is reached. Assumes a register file with combinational read data and a write
// on the clock edge, and that grp_sel is held steady during an instruction.
module ldx_load_exec
    import ldx_pkg::*;
#(
    parameter int SHORT_CYCLES = 6,
    parameter int LONG_CYCLES  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic [3:0] grp_sel,
    output logic [7:0] rf_addr,
    output logic       rf_we,
    output logic [7:0] rf_wdata,
    input  logic [7:0] rf_rdata,
    output logic       done,
    output logic       illegal
);

    typedef enum logic [2:0] {
        S_IDLE, S_OP1, S_OP2, S_PTR, S_SRC, S_WR, S_WAIT, S_ILL
    } exec_state_e;

    exec_state_e state;
    exec_state_e work_first;
    ld_form_e    dec_form;
    logic        dec_long;
    ld_form_e    form_q;
    logic        long_q;
    nib_t        wsel_q;
    rbyte_t      b1_q;
    rbyte_t      b2_q;
    rbyte_t      ptr_q;
    rbyte_t      data_q;
    ld_plan_t    plan;
    logic        accept;
    logic        t_start;
    logic        t_advance;
    logic        t_end;

    ldx_decode u_decode (
        .opcode    (in_data),
        .form      (dec_form),
        .long_form (dec_long)
    );

    ldx_operand_map u_map (
        .form (form_q),
        .wsel (wsel_q),
        .b1   (b1_q),
        .b2   (b2_q),
        .grp  (grp_sel),
        .plan (plan)
    );

    ldx_cycle_timer #(
        .SHORT_CYCLES (SHORT_CYCLES),
        .LONG_CYCLES  (LONG_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (t_start),
        .long_sel (dec_long),
        .advance  (t_advance),
        .at_end   (t_end)
    );

    // Stream handshake and timer control.
    always_comb begin
        in_ready  = (state == S_IDLE) || (state == S_OP1) || (state == S_OP2);
        accept    = in_ready && in_valid;
        t_start   = accept && (state == S_IDLE) && (dec_form != FM_BAD);
        t_advance = !(in_ready && !in_valid);
    end

    // First work step once all operand bytes are in.
    always_comb begin
        if (plan.need_ptr)     work_first = S_PTR;
        else if (plan.src_imm) work_first = S_WR;
        else                   work_first = S_SRC;
    end

    // Sequencer: fetch bytes, read pointer and source, write, wait out the length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            form_q <= FM_BAD;
            long_q <= 1'b0;
            wsel_q <= '0;
            b1_q   <= '0;
            b2_q   <= '0;
            ptr_q  <= '0;
            data_q <= '0;
        end else begin
            case (state)
                S_IDLE: if (accept) begin
                    form_q <= dec_form;
                    long_q <= dec_long;
                    wsel_q <= in_data[7:4];
                    state  <= (dec_form == FM_BAD) ? S_ILL : S_OP1;
                end
                S_OP1: if (accept) begin
                    b1_q  <= in_data;
                    state <= long_q ? S_OP2 : work_first;
                end
                S_OP2: if (accept) begin
                    b2_q  <= in_data;
                    state <= work_first;
                end
                S_PTR: begin
                    ptr_q <= rf_rdata + plan.off;
                    state <= plan.src_imm ? S_WR : S_SRC;
                end
                S_SRC: begin
                    data_q <= rf_rdata;
                    state  <= S_WR;
                end
                S_WR:    state <= S_WAIT;
                S_WAIT:  if (t_end) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Register-file port driven from the current step.
    always_comb begin
        rf_addr  = '0;
        rf_we    = 1'b0;
        rf_wdata = '0;
        case (state)
            S_PTR: rf_addr = plan.ptr_addr;
            S_SRC: rf_addr = (plan.need_ptr && plan.ptr_is_src) ? ptr_q : plan.src_addr;
            S_WR: begin
                rf_we    = 1'b1;
                rf_addr  = (plan.need_ptr && !plan.ptr_is_src) ? ptr_q : plan.dst_addr;
                rf_wdata = plan.src_imm ? plan.imm : data_q;
            end
            default: rf_addr = '0;
        endcase
    end

    // Completion and rejection pulses.
    always_comb begin
        illegal = (state == S_ILL);
        done    = illegal || ((state == S_WAIT) && t_end);
    end

    // R9
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R10
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !rf_we && $past(in_ready)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && in_ready));

    // R11
    no_fetch_while_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !in_ready);

endmodule

// File: tb/sim_ldx_load_exec.sv
// Bench for ldx_load_exec. A behavioural model of the register file and of the
// instruction set predicts the memory image after every instruction. The
// per-cycle handshake, completion and write activity are compared each clock.
module sim_ldx_load_exec;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [3:0] grp_sel = 4'h0;
    logic       in_ready;
    logic [7:0] rf_addr;
    logic       rf_we;
    logic [7:0] rf_wdata;
    logic [7:0] rf_rdata;
    logic       done;
    logic       illegal;

    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];

    int  vectors = 0;
    int  misses  = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    ldx_load_exec u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .grp_sel  (grp_sel),
        .rf_addr  (rf_addr),
        .rf_we    (rf_we),
        .rf_wdata (rf_wdata),
        .rf_rdata (rf_rdata),
        .done     (done),
        .illegal  (illegal)
    );

    // Register file: combinational read, clocked write, seeded during reset.
    assign rf_rdata = mem[rf_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 29 + 7);
        end else if (rf_we) begin
            mem[rf_addr] <= rf_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] wr_a(input logic [3:0] g, input logic [3:0] n);
        return {g, n};
    endfunction

    function automatic logic [7:0] fld_a(input logic [3:0] g, input logic [7:0] f);
        return (f[7:4] == 4'hE) ? {g, f[3:0]} : f;
    endfunction

    function automatic bit is_legal(input logic [7:0] op);
        return (op[3:0] == 4'hC) || (op[3:0] == 4'h8) || (op[3:0] == 4'h9) ||
               (op inside {8'hE3, 8'hF3, 8'hE4, 8'hE5, 8'hE6, 8'hE7,
                           8'hF5, 8'hC7, 8'hD7});
    endfunction

    // Behavioural instruction model applied to ref_mem.
    task automatic model(input logic [3:0] g, input logic [7:0] op,
                         input logic [7:0] b1, input logic [7:0] b2);
        logic [7:0] a, v;
        if (op[3:0] == 4'hC) begin
            a = wr_a(g, op[7:4]); v = b1;
        end else if (op[3:0] == 4'h8) begin
            a = wr_a(g, op[7:4]); v = ref_mem[fld_a(g, b1)];
        end else if (op[3:0] == 4'h9) begin
            a = fld_a(g, b1); v = ref_mem[wr_a(g, op[7:4])];
        end else begin
            case (op)
                8'hE3: begin a = wr_a(g, b1[7:4]); v = ref_mem[ref_mem[wr_a(g, b1[3:0])]]; end
                8'hF3: begin a = ref_mem[wr_a(g, b1[7:4])]; v = ref_mem[wr_a(g, b1[3:0])]; end
                8'hE4: begin a = fld_a(g, b2); v = ref_mem[fld_a(g, b1)]; end
                8'hE5: begin a = fld_a(g, b2); v = ref_mem[ref_mem[fld_a(g, b1)]]; end
                8'hF5: begin a = ref_mem[fld_a(g, b2)]; v = ref_mem[fld_a(g, b1)]; end
                8'hE6: begin a = fld_a(g, b1); v = b2; end
                8'hE7: begin a = ref_mem[fld_a(g, b1)]; v = b2; end
                8'hC7: begin a = wr_a(g, b1[7:4]); v = ref_mem[8'(ref_mem[wr_a(g, b1[3:0])] + b2)]; end
                default: begin a = 8'(ref_mem[wr_a(g, b1[3:0])] + b2); v = ref_mem[wr_a(g, b1[7:4])]; end
            endcase
        end
        ref_mem[a] = v;
    endtask

    // Drive one instruction, compare every cycle, then compare the memory image.
    task automatic run(input logic [3:0] g, input logic [7:0] op, input logic [7:0] b1,
                       input logic [7:0] b2, input int stalls, input string req);
        bit         legal = is_legal(op);
        bit         two = legal && (op inside {8'hE4, 8'hE5, 8'hE6, 8'hE7,
                                               8'hF5, 8'hC7, 8'hD7});
        int         nops = legal ? (two ? 2 : 1) : 0;
        int         len = legal ? ((two ? 10 : 6) + stalls * nops) : 2;
        logic       v_seq [16];
        logic [7:0] d_seq [16];
        int         nseq = 0;
        int         writes = 0;
        int         bad = 0;
        int         first = -1;
        v_seq[nseq] = 1'b1; d_seq[nseq] = op; nseq++;
        for (int o = 0; o < nops; o++) begin
            for (int s = 0; s < stalls; s++) begin
                v_seq[nseq] = 1'b0; d_seq[nseq] = 8'hA5; nseq++;
            end
            v_seq[nseq] = 1'b1; d_seq[nseq] = (o == 0) ? b1 : b2; nseq++;
        end
        if (legal) model(g, op, b1, b2);
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            // R11 handshake, R8 completion cycle, R10 rejection flag
            chk(in_ready == (k <= nseq), "R11", "in_ready", int'(in_ready), int'(k <= nseq));
            chk(done == (k == len), "R8", "done", int'(done), int'(k == len));
            chk(illegal == (!legal && k == len), "R10", "illegal", int'(illegal),
                int'(!legal && k == len));
            if (rf_we) writes++;
            grp_sel = g;
            if (k <= nseq) begin
                in_valid = v_seq[k-1];
                in_data  = d_seq[k-1];
            end else begin
                in_valid = 1'b0;
                in_data  = 8'h5A;
            end
        end
        @(posedge clk);
        #1;
        chk(writes == (legal ? 1 : 0), legal ? "R9" : "R10", "write count",
            writes, legal ? 1 : 0);
        for (int i = 0; i < 256; i++) begin
            if (mem[i] !== ref_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first >= 0)
            $display("     at address %0h (opcode %0h)", first, op);
        chk(bad == 0, req, "memory image", (first >= 0) ? int'(mem[first]) : 0,
            (first >= 0) ? int'(ref_mem[first]) : 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i * 29 + 7);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
        chk(done == 1'b0, "R1", "done", int'(done), 0);
        chk(illegal == 1'b0, "R1", "illegal", int'(illegal), 0);
        chk(rf_we == 1'b0, "R1", "rf_we", int'(rf_we), 0);
        rst_n = 1'b1;

        run(4'h2, 8'hFC, 8'h34, 8'h00, 0, "R3");
        run(4'h2, 8'h38, 8'h91, 8'h00, 0, "R3");
        run(4'h2, 8'h58, 8'hE7, 8'h00, 0, "R2");
        run(4'h2, 8'h49, 8'hA0, 8'h00, 0, "R3");
        run(4'h2, 8'h6C, 8'hC5, 8'h00, 0, "R3");
        run(4'h2, 8'hE3, 8'h26, 8'h00, 0, "R4");
        run(4'h2, 8'hF3, 8'h61, 8'h00, 0, "R4");
        run(4'h2, 8'hE4, 8'h80, 8'h81, 0, "R5");
        run(4'h2, 8'hE5, 8'hE6, 8'h90, 0, "R5");
        run(4'h2, 8'hF5, 8'h33, 8'h40, 0, "R5");
        run(4'h2, 8'hE6, 8'hEA, 8'h5A, 0, "R6");
        run(4'h2, 8'hE7, 8'h44, 8'h77, 0, "R6");
        run(4'h2, 8'hE7, 8'hE6, 8'h3C, 0, "R6");
        run(4'h2, 8'h4C, 8'h20, 8'h00, 0, "R7");
        run(4'h2, 8'hC7, 8'h34, 8'hF0, 0, "R7");
        run(4'h2, 8'hD7, 8'h94, 8'h05, 0, "R7");
        run(4'h2, 8'h00, 8'h00, 8'h00, 0, "R10");
        run(4'h2, 8'hE2, 8'h00, 8'h00, 0, "R10");
        run(4'h2, 8'hFF, 8'h00, 8'h00, 0, "R10");
        run(4'h2, 8'hE4, 8'h12, 8'hE1, 3, "R11");
        run(4'h2, 8'h3C, 8'h99, 8'h00, 2, "R11");
        run(4'h7, 8'h1C, 8'hAB, 8'h00, 0, "R2");
        run(4'h7, 8'hE4, 8'hE1, 8'hE9, 0, "R2");

        for (int n = 0; n < 300; n++) begin
            logic [7:0] op;
            logic [3:0] hi = 4'($urandom);
            case ($urandom % 13)
                0:  op = {hi, 4'hC};
                1:  op = {hi, 4'h8};
                2:  op = {hi, 4'h9};
                3:  op = 8'hE3;
                4:  op = 8'hF3;
                5:  op = 8'hE4;
                6:  op = 8'hE5;
                7:  op = 8'hE6;
                8:  op = 8'hE7;
                9:  op = 8'hF5;
                10: op = 8'hC7;
                11: op = 8'hD7;
                default: op = {hi, 4'h1};
            endcase
            run(4'($urandom), op, 8'($urandom), 8'($urandom), int'($urandom % 3), "R9");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL R8 watchdog: actual %0h expected %0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule